// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item Copy Engine

This block serves a small set of read-only configuration items to software. A selector register picks one item. A data register then returns the item's bytes one at a time, starting from a per-item cursor that advances on each read. A second path lets software copy many bytes at once. Software places a 16-byte descriptor in system memory and writes the descriptor's memory address to a pointer register. The engine then fetches the descriptor over a byte-wide memory master port and copies bytes from the selected item into memory. When it finishes, it writes its progress and status back into the descriptor.

The descriptor stores its three fields most significant byte first: a 64-bit destination address, then a 32-bit byte count, then a 32-bit control word. A destination of zero turns the copy into a skip: the cursor moves forward and nothing is stored. On completion the destination and count fields show exactly how far the transfer got. The control word becomes zero on success, or has bit 0 set on failure.

Top module: `cfgdma_top`

## Requirements
- R1: After reset `mmio_rdata` is 0, no memory request is raised, the selector is 0 and the cursor is at byte 0 of item 0.
- R2: Item i (i below 4) is 5+4*i bytes long, and its byte at cursor k is (64*i + 3*k + 1) mod 256. A selector of 4 or more names an item of length 0. A read at offset 0x00 returns the byte at the cursor in bits [7:0] and advances the cursor by one. At or past the end of the item it returns 0 and the cursor stays put.
- R3: A write at offset 0x08 loads the selector from bits [15:0] and moves the cursor back to 0. A read at 0x08 returns the selector.
- R4: The 64-bit pointer is written as an upper half at offset 0x10 and a lower half at 0x14. Only the write of the lower half starts a transfer. Reads at 0x10 and 0x14 return 0.
- R5: A transfer first reads the 16 descriptor bytes at P..P+15 in ascending order, where P is the pointer. Bytes 0-7 form the destination, 8-11 the count and 12-15 the control word, each most significant byte first.
- R6: With control 2 and a nonzero destination, the engine writes the item's bytes from the cursor to successive destination addresses and advances the cursor once per byte. It then writes back destination+count, count 0 and control 0.
- R7: With control 2 and destination 0, no byte is written to memory and the cursor advances by the count. The write-back holds destination 0, count 0 and control 0.
- R8: When the cursor reaches the end of the item, the remaining bytes are dropped unwritten. The write-back shows count 0, the destination just past the last byte stored, and control 0.
- R9: An error response to a byte write stops the copy. The write-back shows the destination and count before the failed byte and control 1. Only the successful bytes advance the cursor.
- R10: A control value other than 2 copies nothing. The write-back returns the fetched destination and count unchanged, with control 1.
- R11: While a transfer is in progress, pointer writes are ignored, selector writes are ignored, and data reads return 0 without moving the cursor.
- R12: A request holds `mem_req_valid`, address and data steady until `mem_req_ready`. At most one request is outstanding. The write-back stores the 16 bytes at P..P+15 in the descriptor's byte order.
- R13: An error response during the descriptor fetch ends the transfer with no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mmio_valid | input | 1 | Register access strobe, one cycle |
| mmio_we | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | 5 | Register byte offset |
| mmio_wdata | input | 32 | Register write data |
| mmio_rdata | output | 32 | Read data, valid the cycle after a read |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 8 | Read byte |
| mem_rsp_err | input | 1 | Response reports a failed access |

## Verification
Both the register interface and the copy engine can try to advance the shared item cursor in the same cycle. The bench provokes this by issuing data reads, selector writes and a second pointer start immediately after launching a transfer, while the engine is still fetching or copying. The result is judged in three ways. The colliding data read must return 0. The scoreboard must see exactly the expected byte writes and no second transfer. After the write-back, a data read must return the byte just past the copied range of the originally selected item.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    localparam int DESC_BYTES = 16;

    localparam logic [4:0] OFS_DATA   = 5'h00;
    localparam logic [4:0] OFS_SEL    = 5'h08;
    localparam logic [4:0] OFS_PTR_HI = 5'h10;
    localparam logic [4:0] OFS_PTR_LO = 5'h14;

    localparam logic [31:0] CTL_READ = 32'd2;
    localparam logic [31:0] CTL_ERR  = 32'd1;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_CHECK,
        ENG_COPY,
        ENG_WB
    } eng_state_e;

endpackage

// File: rtl/cfgdma_item_rom.sv
module cfgdma_item_rom #(
    parameter int N_ITEMS  = 4,
    parameter int SEL_W    = 16,
    parameter int OFF_W    = 8,
    parameter int LEN_BASE = 5,
    parameter int LEN_STEP = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [OFF_W-1:0] offset,
    output logic [OFF_W-1:0] item_len,
    output logic [7:0]       item_byte
);
    localparam int IDX_W = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1;

    logic [OFF_W-1:0] len_tab [N_ITEMS];

    for (genvar g = 0; g < N_ITEMS; g++) begin : g_len
        assign len_tab[g] = OFF_W'(LEN_BASE + LEN_STEP * g);
    end

    logic [7:0] sel_term;
    logic [7:0] off_term;

    always_comb begin
        item_len = '0;
        if (sel < SEL_W'(N_ITEMS)) begin
            item_len = len_tab[sel[IDX_W-1:0]];
        end
        sel_term  = {sel[1:0], 6'b0};
        off_term  = 8'(offset) * 8'd3;
        item_byte = sel_term + off_term + 8'd1;
    end

endmodule

// File: rtl/cfgdma_cursor.sv
module cfgdma_cursor #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_write,
    input  logic             mmio_step,
    input  logic             dma_step,
    input  logic [OFF_W-1:0] item_len,
    output logic [OFF_W-1:0] offset,
    output logic             at_end
);
    typedef struct packed {
        logic [OFF_W-1:0] offset;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (sel_write) begin
            cur_d.offset = '0;
        end else if (mmio_step || dma_step) begin
            cur_d.offset = cur_q.offset + OFF_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign offset = cur_q.offset;
    assign at_end = (cur_q.offset >= item_len);

endmodule

// File: rtl/cfgdma_mmio.sv
module cfgdma_mmio
    import cfgdma_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mmio_valid,
    input  logic             mmio_we,
    input  logic [4:0]       mmio_addr,
    input  logic [31:0]      mmio_wdata,
    output logic [31:0]      mmio_rdata,
    input  logic             busy,
    input  logic             at_end,
    input  logic [7:0]       item_byte,
    output logic [SEL_W-1:0] sel,
    output logic             sel_write,
    output logic             mmio_step,
    output logic             start,
    output logic [63:0]      start_ptr
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [31:0]      ptr_hi;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ok;
    logic rd_ok;

    always_comb begin
        r_d       = r_q;
        wr_ok     = mmio_valid && mmio_we && !busy;
        rd_ok     = mmio_valid && !mmio_we;
        sel_write = 1'b0;
        mmio_step = 1'b0;
        start     = 1'b0;
        start_ptr = {r_q.ptr_hi, mmio_wdata};

        if (wr_ok) begin
            case (mmio_addr)
                OFS_SEL:    begin
                    r_d.sel   = mmio_wdata[SEL_W-1:0];
                    sel_write = 1'b1;
                end
                OFS_PTR_HI: r_d.ptr_hi = mmio_wdata;
                OFS_PTR_LO: start = 1'b1;
                default:    ;
            endcase
        end

        if (rd_ok) begin
            case (mmio_addr)
                OFS_DATA: begin
                    if (!busy && !at_end) begin
                        r_d.rdata = {24'b0, item_byte};
                        mmio_step = 1'b1;
                    end else begin
                        r_d.rdata = '0;
                    end
                end
                OFS_SEL: r_d.rdata = 32'(r_q.sel);
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mmio_rdata = r_q.rdata;
    assign sel        = r_q.sel;

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] start_ptr,
    input  logic        at_end,
    input  logic [7:0]  item_byte,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [63:0] mem_req_addr,
    output logic [7:0]  mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [7:0]  mem_rsp_rdata,
    input  logic        mem_rsp_err,
    output logic        busy,
    output logic        dma_step
);
    localparam int CNT_W = $clog2(DESC_BYTES);
    localparam int BLK_W = DESC_BYTES * 8;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DESC_BYTES - 1);

    typedef struct packed {
        eng_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [63:0]      ptr;
        logic [BLK_W-1:0] desc;
        logic             err;
        logic             wait_rsp;
    } eng_t;

    eng_t e_d, e_q;

    logic [63:0]      dst;
    logic [31:0]      len;
    logic [31:0]      ctl;
    logic [BLK_W-1:0] wb_blk;
    logic [BLK_W-1:0] wb_shift;
    logic [CNT_W+2:0] wb_sh;
    logic             rsp_here;

    always_comb begin
        e_d           = e_q;
        dma_step      = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;

        dst      = e_q.desc[BLK_W-1 -: 64];
        len      = e_q.desc[63:32];
        ctl      = e_q.desc[31:0];
        wb_blk   = {dst, len, (e_q.err ? CTL_ERR : 32'd0)};
        wb_sh    = {~e_q.cnt, 3'b000};
        wb_shift = wb_blk >> wb_sh;
        rsp_here = e_q.wait_rsp && mem_rsp_valid;

        case (e_q.st)
            ENG_IDLE: begin
                if (start) begin
                    e_d.st       = ENG_FETCH;
                    e_d.ptr      = start_ptr;
                    e_d.cnt      = '0;
                    e_d.err      = 1'b0;
                    e_d.wait_rsp = 1'b0;
                end
            end

            ENG_FETCH: begin
                mem_req_valid = !e_q.wait_rsp;
                mem_req_addr  = e_q.ptr + 64'(e_q.cnt);
                if (mem_req_valid && mem_req_ready) begin
                    e_d.wait_rsp = 1'b1;
                end
                if (rsp_here) begin
                    e_d.wait_rsp = 1'b0;
                    if (mem_rsp_err) begin
                        e_d.st = ENG_IDLE;
                    end else begin
                        e_d.desc = {e_q.desc[BLK_W-9:0], mem_rsp_rdata};
                        e_d.cnt  = e_q.cnt + CNT_W'(1);
                        if (e_q.cnt == CNT_LAST) begin
                            e_d.st = ENG_CHECK;
                        end
                    end
                end
            end

            ENG_CHECK: begin
                e_d.cnt = '0;
                if (ctl != CTL_READ) begin
                    e_d.err = 1'b1;
                    e_d.st  = ENG_WB;
                end else begin
                    e_d.st = ENG_COPY;
                end
            end

            ENG_COPY: begin
                if (e_q.wait_rsp) begin
                    if (mem_rsp_valid) begin
                        e_d.wait_rsp = 1'b0;
                        if (mem_rsp_err) begin
                            e_d.err = 1'b1;
                            e_d.st  = ENG_WB;
                            e_d.cnt = '0;
                        end else begin
                            e_d.desc[BLK_W-1 -: 64] = dst + 64'd1;
                            e_d.desc[63:32]         = len - 32'd1;
                            dma_step                = 1'b1;
                        end
                    end
                end else if (len == 32'd0) begin
                    e_d.st  = ENG_WB;
                    e_d.cnt = '0;
                end else if (at_end) begin
                    e_d.desc[63:32] = '0;
                end else if (dst == 64'd0) begin
                    e_d.desc[63:32] = len - 32'd1;
                    dma_step        = 1'b1;
                end else begin
                    mem_req_valid = 1'b1;
                    mem_req_write = 1'b1;
                    mem_req_addr  = dst;
                    mem_req_wdata = item_byte;
                    if (mem_req_ready) begin
                        e_d.wait_rsp = 1'b1;
                    end
                end
            end

            ENG_WB: begin
                mem_req_valid = !e_q.wait_rsp;
                mem_req_write = 1'b1;
                mem_req_addr  = e_q.ptr + 64'(e_q.cnt);
                mem_req_wdata = wb_shift[7:0];
                if (mem_req_valid && mem_req_ready) begin
                    e_d.wait_rsp = 1'b1;
                end
                if (rsp_here) begin
                    e_d.wait_rsp = 1'b0;
                    e_d.cnt      = e_q.cnt + CNT_W'(1);
                    if (e_q.cnt == CNT_LAST) begin
                        e_d.st = ENG_IDLE;
                    end
                end
            end

            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ENG_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy = (e_q.st != ENG_IDLE);

endmodule

// File: rtl/cfgdma_top.sv
module cfgdma_top
    import cfgdma_pkg::*;
#(
    parameter int N_ITEMS  = 4,
    parameter int SEL_W    = 16,
    parameter int OFF_W    = 8,
    parameter int LEN_BASE = 5,
    parameter int LEN_STEP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mmio_valid,
    input  logic        mmio_we,
    input  logic [4:0]  mmio_addr,
    input  logic [31:0] mmio_wdata,
    output logic [31:0] mmio_rdata,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [63:0] mem_req_addr,
    output logic [7:0]  mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [7:0]  mem_rsp_rdata,
    input  logic        mem_rsp_err
);
    logic [SEL_W-1:0] sel_w;
    logic             sel_write_w;
    logic             mmio_step_w;
    logic             dma_step_w;
    logic             start_w;
    logic [63:0]      start_ptr_w;
    logic             busy_w;
    logic [OFF_W-1:0] offset_w;
    logic [OFF_W-1:0] item_len_w;
    logic [7:0]       item_byte_w;
    logic             at_end_w;

    cfgdma_item_rom #(
        .N_ITEMS (N_ITEMS),
        .SEL_W   (SEL_W),
        .OFF_W   (OFF_W),
        .LEN_BASE(LEN_BASE),
        .LEN_STEP(LEN_STEP)
    ) u_rom (
        .sel      (sel_w),
        .offset   (offset_w),
        .item_len (item_len_w),
        .item_byte(item_byte_w)
    );

    cfgdma_cursor #(
        .OFF_W(OFF_W)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_write(sel_write_w),
        .mmio_step(mmio_step_w),
        .dma_step (dma_step_w),
        .item_len (item_len_w),
        .offset   (offset_w),
        .at_end   (at_end_w)
    );

    cfgdma_mmio #(
        .SEL_W(SEL_W)
    ) u_mmio (
        .clk       (clk),
        .rst_n     (rst_n),
        .mmio_valid(mmio_valid),
        .mmio_we   (mmio_we),
        .mmio_addr (mmio_addr),
        .mmio_wdata(mmio_wdata),
        .mmio_rdata(mmio_rdata),
        .busy      (busy_w),
        .at_end    (at_end_w),
        .item_byte (item_byte_w),
        .sel       (sel_w),
        .sel_write (sel_write_w),
        .mmio_step (mmio_step_w),
        .start     (start_w),
        .start_ptr (start_ptr_w)
    );

    cfgdma_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_w),
        .start_ptr    (start_ptr_w),
        .at_end       (at_end_w),
        .item_byte    (item_byte_w),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_err  (mem_rsp_err),
        .busy         (busy_w),
        .dma_step     (dma_step_w)
    );

endmodule

// File: rtl/cfgdma_checker.sv
module cfgdma_checker
    import cfgdma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mmio_valid,
    input logic        mmio_we,
    input logic [4:0]  mmio_addr,
    input logic [31:0] mmio_rdata,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [63:0] mem_req_addr,
    input logic [7:0]  mem_req_wdata,
    input logic        mem_rsp_valid,
    input logic        busy,
    input logic        mmio_step,
    input logic        dma_step
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            out_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            out_q <= 1'b0;
        end
    end

    // R1: no request in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !mem_req_valid);

    // R12: request held steady until accepted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
            && $stable(mem_req_wdata));

    // R12: one outstanding request at most
    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !mem_req_valid);

    // R11: data read during a transfer returns zero
    a_r11_busy_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mmio_valid && !mmio_we && (mmio_addr == OFS_DATA) |=>
            (mmio_rdata == 32'd0));

    // R11: the cursor is never stepped by both sides in one cycle
    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(mmio_step && dma_step));

endmodule

bind cfgdma_top cfgdma_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mmio_valid   (mmio_valid),
    .mmio_we      (mmio_we),
    .mmio_addr    (mmio_addr),
    .mmio_rdata   (mmio_rdata),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .busy         (busy_w),
    .mmio_step    (mmio_step_w),
    .dma_step     (dma_step_w)
);

// File: tb/cfgdma_top_bench.sv
module cfgdma_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmio_valid = 1'b0;
    logic        mmio_we = 1'b0;
    logic [4:0]  mmio_addr = '0;
    logic [31:0] mmio_wdata = '0;
    logic [31:0] mmio_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [63:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_rdata = '0;
    logic        mem_rsp_err = 1'b0;

    always #10 clk = ~clk;

    cfgdma_top u_cfgdma_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .mmio_valid   (mmio_valid),
        .mmio_we      (mmio_we),
        .mmio_addr    (mmio_addr),
        .mmio_wdata   (mmio_wdata),
        .mmio_rdata   (mmio_rdata),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_err  (mem_rsp_err)
    );

    typedef struct {
        logic [63:0] a;
        logic [7:0]  d;
        string       tag;
    } wr_t;

    wr_t         exp_q[$];
    logic [7:0]  mem [logic [63:0]];
    int          n_checks = 0;
    int          n_err = 0;
    bit          finished = 1'b0;
    bit          err_en = 1'b0;
    logic [63:0] err_addr = '0;

    function automatic int item_len(int i);
        return (i < 4) ? 5 + 4 * i : 0;
    endfunction

    function automatic logic [7:0] item_byte(int i, int k);
        return 8'(64 * i + 3 * k + 1);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // memory model and write monitor (scoreboard consumer)
    initial begin
        bit          hs_pend = 1'b0;
        bit          stall = 1'b0;
        logic [63:0] hs_a = '0;
        logic        hs_w = 1'b0;
        logic [7:0]  hs_d = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            mem_req_ready = 1'b0;
            if (hs_pend) begin
                bit e;
                hs_pend = 1'b0;
                e = err_en && (hs_a == err_addr);
                if (hs_w) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R12", "unexpected write addr", hs_a, 64'h0);
                    end else begin
                        wr_t x;
                        x = exp_q.pop_front();
                        chk(hs_a == x.a, x.tag, "write address", hs_a, x.a);
                        chk(hs_d == x.d, x.tag, "write data", 64'(hs_d), 64'(x.d));
                    end
                    if (!e) mem[hs_a] = hs_d;
                end else begin
                    mem_rsp_rdata = mem.exists(hs_a) ? mem[hs_a] : 8'h00;
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = e;
            end else if (mem_req_valid) begin
                stall = ~stall;
                if (!stall) begin
                    mem_req_ready = 1'b1;
                    hs_pend = 1'b1;
                    hs_a = mem_req_addr;
                    hs_w = mem_req_write;
                    hs_d = mem_req_wdata;
                end
            end
        end
    end

    task automatic mmio_wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        mmio_valid = 1'b1; mmio_we = 1'b1; mmio_addr = a; mmio_wdata = d;
        @(negedge clk);
        mmio_valid = 1'b0; mmio_we = 1'b0;
    endtask

    task automatic mmio_rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        mmio_valid = 1'b1; mmio_we = 1'b0; mmio_addr = a;
        @(negedge clk);
        mmio_valid = 1'b0;
        d = mmio_rdata;
    endtask

    function automatic logic [127:0] blk(logic [63:0] dst, logic [31:0] len, logic [31:0] ctl);
        return {dst, len, ctl};
    endfunction

    task automatic put_desc(logic [63:0] p, logic [63:0] dst, logic [31:0] len, logic [31:0] ctl);
        logic [127:0] b;
        b = blk(dst, len, ctl);
        for (int i = 0; i < 16; i++) mem[p + 64'(i)] = b[127 - 8 * i -: 8];
    endtask

    task automatic expect_copy(logic [63:0] dst, int item, int off, int n, string tag);
        for (int i = 0; i < n; i++) begin
            wr_t x;
            x.a = dst + 64'(i); x.d = item_byte(item, off + i); x.tag = tag;
            exp_q.push_back(x);
        end
    endtask

    task automatic expect_wb(logic [63:0] p, logic [63:0] dst, logic [31:0] len,
                             logic [31:0] ctl, string tag);
        logic [127:0] b;
        b = blk(dst, len, ctl);
        for (int i = 0; i < 16; i++) begin
            wr_t x;
            x.a = p + 64'(i); x.d = b[127 - 8 * i -: 8]; x.tag = tag;
            exp_q.push_back(x);
        end
    endtask

    task automatic kick(logic [63:0] p);
        mmio_wr(5'h10, p[63:32]);
        mmio_wr(5'h14, p[31:0]);
    endtask

    task automatic settle(string tag);
        repeat (400) @(negedge clk);
        chk(exp_q.size() == 0, tag, "writes still pending", 64'(exp_q.size()), 64'h0);
    endtask

    task automatic rd_expect(logic [4:0] a, logic [31:0] exp, string tag, string what);
        logic [31:0] v;
        mmio_rd(a, v);
        chk(v == exp, tag, what, 64'(v), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mmio_rdata == 32'd0, "R1", "rdata after reset", 64'(mmio_rdata), 64'h0);
        chk(mem_req_valid == 1'b0, "R1", "request after reset", 64'(mem_req_valid), 64'h0);
        rst_n = 1'b1;
        rd_expect(5'h08, 32'd0, "R1", "selector after reset");
        rd_expect(5'h00, 32'(item_byte(0, 0)), "R1", "first byte item0");

        // R2 / R3: register reads
        mmio_wr(5'h08, 32'd1);
        rd_expect(5'h08, 32'd1, "R3", "selector readback");
        for (int k = 0; k < 3; k++)
            rd_expect(5'h00, 32'(item_byte(1, k)), "R2", "item1 byte");
        mmio_wr(5'h08, 32'd1);
        rd_expect(5'h00, 32'(item_byte(1, 0)), "R3", "cursor back to 0");
        mmio_wr(5'h08, 32'd7);
        rd_expect(5'h00, 32'd0, "R2", "item out of range");
        rd_expect(5'h10, 32'd0, "R4", "pointer hi write-only");
        rd_expect(5'h14, 32'd0, "R4", "pointer lo write-only");

        // R5 / R6 copy with collisions (R11)
        mmio_wr(5'h08, 32'd2);
        rd_expect(5'h00, 32'(item_byte(2, 0)), "R2", "item2 byte0");
        rd_expect(5'h00, 32'(item_byte(2, 1)), "R2", "item2 byte1");
        put_desc(64'h1000, 64'h2000, 32'd5, 32'd2);
        put_desc(64'h1600, 64'h6000, 32'd2, 32'd2);
        expect_copy(64'h2000, 2, 2, 5, "R6");
        expect_wb(64'h1000, 64'h2005, 32'd0, 32'd0, "R5");
        kick(64'h1000);
        rd_expect(5'h00, 32'd0, "R11", "data read while busy");
        mmio_wr(5'h08, 32'd1);
        kick(64'h1600);
        settle("R11");
        rd_expect(5'h08, 32'd2, "R11", "selector kept while busy");
        rd_expect(5'h00, 32'(item_byte(2, 7)), "R6", "cursor after copy");

        // R7 skip
        mmio_wr(5'h08, 32'd0);
        put_desc(64'h1100, 64'h0, 32'd3, 32'd2);
        expect_wb(64'h1100, 64'h0, 32'd0, 32'd0, "R7");
        kick(64'h1100);
        settle("R7");
        rd_expect(5'h00, 32'(item_byte(0, 3)), "R7", "cursor after skip");

        // R8 end of item
        mmio_wr(5'h08, 32'd1);
        for (int k = 0; k < 6; k++)
            rd_expect(5'h00, 32'(item_byte(1, k)), "R2", "item1 walk");
        put_desc(64'h1200, 64'h3000, 32'd10, 32'd2);
        expect_copy(64'h3000, 1, 6, 3, "R8");
        expect_wb(64'h1200, 64'h3003, 32'd0, 32'd0, "R8");
        kick(64'h1200);
        settle("R8");
        rd_expect(5'h00, 32'd0, "R8", "cursor at end");

        // R9 write error
        mmio_wr(5'h08, 32'd3);
        put_desc(64'h1300, 64'h4000, 32'd6, 32'd2);
        err_en = 1'b1; err_addr = 64'h4002;
        expect_copy(64'h4000, 3, 0, 3, "R9");
        expect_wb(64'h1300, 64'h4002, 32'd4, 32'd1, "R9");
        kick(64'h1300);
        settle("R9");
        err_en = 1'b0;
        rd_expect(5'h00, 32'(item_byte(3, 2)), "R9", "cursor after error");

        // R13 fetch error, then R10 recovery with bad control
        put_desc(64'h1500, 64'h7000, 32'd2, 32'd2);
        err_en = 1'b1; err_addr = 64'h1505;
        kick(64'h1500);
        settle("R13");
        err_en = 1'b0;
        rd_expect(5'h00, 32'(item_byte(3, 3)), "R13", "cursor after fetch error");
        put_desc(64'h1400, 64'h5000, 32'd4, 32'd3);
        expect_wb(64'h1400, 64'h5000, 32'd4, 32'd1, "R10");
        kick(64'h1400);
        settle("R10");
        rd_expect(5'h00, 32'(item_byte(3, 4)), "R10", "cursor untouched");

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "R12", "watchdog expired", 64'h0, 64'h1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule